// File: doc/BRIEF.md
# Programmable Logic Macrocell

This block is a single configurable output cell for a complex programmable device. A sum-of-products signal arrives from the product-term array, and the cell either passes it straight through or stores it in a D flip-flop. It can then invert the result before the value leaves the cell. The result goes to two places: the pad data and enable pair that drives the tristate pad buffer, and a feedback line that returns to the shared interconnect for other cells to use.

Static configuration inputs choose four things: the register clock source, combinational or registered output, polarity, and the source of the pad enable. There is only one real clock. When the local product-term clock is selected, its rising edge is detected against the global clock and used as a clock enable for the flip-flop.

Top module: `plm_macrocell`

## Requirements
- R1: With `cfg_registered`=0, `fb_o` equals `sop_in` XOR `cfg_invert` in the same cycle, whatever the stored bit holds.
- R2: With `cfg_clk_local`=0, the flip-flop captures `sop_in` at every global clock edge. With `cfg_registered`=1, `fb_o` then shows that captured bit, XOR `cfg_invert`, from the following cycle.
- R3: With `cfg_clk_local`=1, the flip-flop captures `sop_in` only at an edge where `pt_clk` is sampled 1 and was sampled 0 (or was cleared by reset) at the previous edge. At every other edge it holds its value.
- R4: Inversion is applied after the register. A stored 0 with `cfg_invert`=1 reads as 1 on `fb_o`.
- R5: A global clock edge with `rst_n`=0 clears the flip-flop and the edge history to 0, and this takes priority over any capture. A registered, inverted cell therefore reads 1 on `fb_o` during and after reset.
- R6: `pad_en` follows `cfg_oe_mode`: 2'b00 gives 0, 2'b01 gives 1, 2'b10 follows `pt_oe`, and 2'b11 gives 0.
- R7: `pad_data` equals `fb_o` in every cycle, including cycles where `pad_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock shared by all cells |
| rst_n | input | 1 | Synchronous active-low reset |
| sop_in | input | 1 | Sum-of-products input from the array |
| pt_clk | input | 1 | Product-term local clock signal |
| pt_oe | input | 1 | Product-term output enable |
| cfg_clk_local | input | 1 | 1 selects the product-term clock |
| cfg_registered | input | 1 | 1 selects the flip-flop output |
| cfg_invert | input | 1 | 1 complements the result |
| cfg_oe_mode | input | 2 | Pad enable source select |
| pad_data | output | 1 | Data to the pad tristate buffer |
| pad_en | output | 1 | Enable for the pad tristate buffer |
| fb_o | output | 1 | Result fed back to the interconnect |

## Verification
Reset and a local-clock capture can land on the same global edge. The bench provokes this by raising `pt_clk` with `sop_in` at 1 in the cycle where `rst_n` is low. It then judges that the stored bit reads 0 afterwards. It also checks that a `pt_clk` held high through reset release is taken as a fresh rising edge on the first edge out of reset, and that the edge after that holds the value.

// File: rtl/plm_mc_pkg.sv
// Package: shared encodings for the macrocell.
// Assumes: the pad enable select field is two bits wide.
package plm_mc_pkg;
    localparam int OE_SEL_W = 2;

    typedef enum logic [OE_SEL_W-1:0] {
        OE_OFF   = 2'b00,
        OE_ON    = 2'b01,
        OE_PTERM = 2'b10,
        OE_RSVD  = 2'b11
    } oe_mode_e;
endpackage

// File: rtl/mc_clk_sel.sv
// Module: clock source selection as a clock enable.
// With the local source selected, the enable is a one-cycle pulse on a
// sampled rising edge of the product-term clock. Otherwise it is always 1.
// Assumes: pt_clk is synchronous to clk.
module mc_clk_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic use_local,
    input  logic pt_clk,
    output logic cap_en
);
    logic pt_hist;

    // Purpose: remember pt_clk from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) pt_hist <= 1'b0;
        else        pt_hist <= pt_clk;
    end

    // Purpose: form the capture enable for the storage flop.
    always_comb begin
        cap_en = use_local ? (pt_clk & ~pt_hist) : 1'b1;
    end
endmodule

// File: rtl/mc_store.sv
// Module: the macrocell D flip-flop with a capture enable.
// Assumes: synchronous active-low reset that clears the bit to 0.
module mc_store (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic d,
    output logic q
);
    // Purpose: hold the registered sum-of-products bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (cap_en) q <= d;
    end
endmodule

// File: rtl/mc_out_path.sv
// Module: output selection followed by polarity control.
// Assumes: inversion is applied after the register/combinational choice.
module mc_out_path (
    input  logic use_reg,
    input  logic invert,
    input  logic comb_d,
    input  logic reg_d,
    output logic result
);
    logic chosen;

    // Purpose: pick the registered or combinational source, then apply polarity.
    always_comb begin
        chosen = use_reg ? reg_d : comb_d;
        result = chosen ^ invert;
    end
endmodule

// File: rtl/mc_oe_sel.sv
// Module: pad enable source selection.
// Assumes: the reserved encoding disables the pad.
module mc_oe_sel
    import plm_mc_pkg::*;
(
    input  logic [OE_SEL_W-1:0] mode,
    input  logic                pt_oe,
    output logic                en
);
    // Purpose: decode the enable source.
    always_comb begin
        unique case (oe_mode_e'(mode))
            OE_ON:    en = 1'b1;
            OE_PTERM: en = pt_oe;
            default:  en = 1'b0;
        endcase
    end
endmodule

// File: rtl/plm_macrocell.sv
// Module: one configurable macrocell (top).
// Joins the clock enable, the storage flop, the output path and the pad
// enable select. Feedback is taken after the inversion and before the pad.
// Assumes: all configuration inputs are static while the array runs.
module plm_macrocell
    import plm_mc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sop_in,
    input  logic                pt_clk,
    input  logic                pt_oe,
    input  logic                cfg_clk_local,
    input  logic                cfg_registered,
    input  logic                cfg_invert,
    input  logic [OE_SEL_W-1:0] cfg_oe_mode,
    output logic                pad_data,
    output logic                pad_en,
    output logic                fb_o
);
    logic cap_en;
    logic reg_q;
    logic result;

    mc_clk_sel u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .use_local (cfg_clk_local),
        .pt_clk    (pt_clk),
        .cap_en    (cap_en)
    );

    mc_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .d      (sop_in),
        .q      (reg_q)
    );

    mc_out_path u_out (
        .use_reg (cfg_registered),
        .invert  (cfg_invert),
        .comb_d  (sop_in),
        .reg_d   (reg_q),
        .result  (result)
    );

    mc_oe_sel u_oe (
        .mode  (cfg_oe_mode),
        .pt_oe (pt_oe),
        .en    (pad_en)
    );

    // Purpose: fan the result to the interconnect and to the pad buffer.
    always_comb begin
        fb_o     = result;
        pad_data = result;
    end
endmodule

// File: rtl/plm_macrocell_chk.sv
// Module: assertion checker bound to plm_macrocell.
// Assumes: it observes the top's ports and the internal stored bit reg_q.
module plm_macrocell_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sop_in,
    input logic       pt_clk,
    input logic       pt_oe,
    input logic       cfg_clk_local,
    input logic       cfg_registered,
    input logic       cfg_invert,
    input logic [1:0] cfg_oe_mode,
    input logic       pad_data,
    input logic       pad_en,
    input logic       fb_o,
    input logic       reg_q
);
    assert_comb_path_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_registered |-> (fb_o == (sop_in ^ cfg_invert)));

    assert_global_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_clk_local |=> (reg_q == $past(sop_in)));

    assert_local_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clk_local && $past(rst_n) && $past(pt_clk) && pt_clk) |=> $stable(reg_q));

    assert_invert_after_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_registered |-> (fb_o == (reg_q ^ cfg_invert)));

    assert_reset_clear_R5: assert property (@(posedge clk)
        !rst_n |=> (reg_q == 1'b0));

    assert_oe_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_oe_mode == 2'b01) |-> pad_en);

    assert_oe_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_oe_mode[1] == cfg_oe_mode[0]) |-> !pad_en);

    assert_oe_pterm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_oe_mode == 2'b10) |-> (pad_en == pt_oe));

    assert_pad_matches_fb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pad_data == fb_o);
endmodule

bind plm_macrocell plm_macrocell_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .sop_in         (sop_in),
    .pt_clk         (pt_clk),
    .pt_oe          (pt_oe),
    .cfg_clk_local  (cfg_clk_local),
    .cfg_registered (cfg_registered),
    .cfg_invert     (cfg_invert),
    .cfg_oe_mode    (cfg_oe_mode),
    .pad_data       (pad_data),
    .pad_en         (pad_en),
    .fb_o           (fb_o),
    .reg_q          (reg_q)
);

// File: tb/plm_macrocell_tb_top.sv
// Bench: an enable-source table walk, an exhaustive configuration sweep
// against a behavioural model, then directed reset and edge cases.
module plm_macrocell_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sop_in, pt_clk, pt_oe;
    logic       cfg_clk_local, cfg_registered, cfg_invert;
    logic [1:0] cfg_oe_mode;
    logic       pad_data, pad_en, fb_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    plm_macrocell dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .sop_in         (sop_in),
        .pt_clk         (pt_clk),
        .pt_oe          (pt_oe),
        .cfg_clk_local  (cfg_clk_local),
        .cfg_registered (cfg_registered),
        .cfg_invert     (cfg_invert),
        .cfg_oe_mode    (cfg_oe_mode),
        .pad_data       (pad_data),
        .pad_en         (pad_en),
        .fb_o           (fb_o)
    );

    // Behavioural model of the stored bit, built from R2, R3 and R5.
    logic m_q  = 1'b0;
    logic m_pt = 1'b0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_q  <= 1'b0;
            m_pt <= 1'b0;
        end else begin
            if (!cfg_clk_local || (pt_clk && !m_pt)) m_q <= sop_in;
            m_pt <= pt_clk;
        end
    end

    // Enable table: {mode[1:0], pt_oe, expected pad_en} (R6).
    localparam logic [3:0] OE_VEC [8] = '{
        4'b00_0_0, 4'b00_1_0, 4'b01_0_1, 4'b01_1_1,
        4'b10_0_0, 4'b10_1_1, 4'b11_0_0, 4'b11_1_0
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #200000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; sop_in = 1'b1; pt_clk = 1'b0; pt_oe = 1'b0;
        cfg_clk_local = 1'b0; cfg_registered = 1'b1; cfg_invert = 1'b1;
        cfg_oe_mode = 2'b00;
        @(posedge clk); @(negedge clk);
        // R5 / R4: stored bit cleared, inverted view reads 1.
        chk("R5 reset registered inverted fb", fb_o, 1'b1);
        cfg_invert = 1'b0; #1;
        chk("R5 reset registered plain fb", fb_o, 1'b0);
        chk("R6 reset pad_en mode 00", pad_en, 1'b0);

        // Table walk of the enable select (R6).
        for (int i = 0; i < 8; i++) begin
            cfg_oe_mode = OE_VEC[i][3:2];
            pt_oe       = OE_VEC[i][1];
            #1;
            chk("R6 enable table", pad_en, OE_VEC[i][0]);
        end

        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive configuration sweep against the model (R1-related tags below).
        for (int idx = 0; idx < 256; idx++) begin
            @(negedge clk);
            pt_clk         = idx[0];
            sop_in         = idx[1];
            pt_oe          = idx[2];
            cfg_oe_mode    = idx[4:3];
            cfg_invert     = idx[5];
            cfg_registered = idx[6];
            cfg_clk_local  = idx[7];
            #1;
            begin
                logic core, exp_fb, exp_en;
                core   = cfg_registered ? m_q : sop_in;
                exp_fb = core ^ cfg_invert;
                exp_en = (cfg_oe_mode == 2'b01) ? 1'b1 :
                         (cfg_oe_mode == 2'b10) ? pt_oe : 1'b0;
                if (!cfg_registered)     chk("R1 sweep comb fb", fb_o, exp_fb);
                else if (!cfg_clk_local) chk("R2 sweep global reg fb", fb_o, exp_fb);
                else                     chk("R3 sweep local reg fb", fb_o, exp_fb);
                chk("R6 sweep pad_en", pad_en, exp_en);
                chk("R7 sweep pad_data", pad_data, fb_o);
            end
        end

        // Directed: store a 1 with the global clock (R2), then show R4.
        @(negedge clk);
        cfg_clk_local = 1'b0; cfg_registered = 1'b1; cfg_invert = 1'b0;
        cfg_oe_mode = 2'b00; sop_in = 1'b1; pt_clk = 1'b0;
        @(negedge clk);
        chk("R2 global capture of 1", fb_o, 1'b1);
        sop_in = 1'b0; cfg_clk_local = 1'b1; cfg_invert = 1'b1; #1;
        chk("R4 stored 1 inverted", fb_o, 1'b0);
        chk("R7 pad_data while pad disabled", pad_data, 1'b0);
        cfg_invert = 1'b0;

        // Reset collides with a local rising edge: reset wins (R5).
        rst_n = 1'b0; pt_clk = 1'b1; sop_in = 1'b1;
        @(negedge clk);
        chk("R5 reset beats local capture", fb_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 high pt_clk after reset is a fresh edge", fb_o, 1'b1);
        sop_in = 1'b0;
        @(negedge clk);
        chk("R3 held pt_clk does not capture", fb_o, 1'b1);
        @(negedge clk);
        chk("R3 still holding", fb_o, 1'b1);
        pt_clk = 1'b0;
        @(negedge clk);
        chk("R3 falling edge does not capture", fb_o, 1'b1);
        pt_clk = 1'b1;
        @(negedge clk);
        chk("R3 new rising edge captures 0", fb_o, 1'b0);

        // Switching to combinational leaves the stored bit intact (R1).
        sop_in = 1'b1; pt_clk = 1'b1; cfg_registered = 1'b0; #1;
        chk("R1 comb view of sop", fb_o, 1'b1);
        @(negedge clk);
        cfg_registered = 1'b1; #1;
        chk("R3 stored bit untouched while comb selected", fb_o, 1'b0);

        finish_run();
    end
endmodule